// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block is the host-facing front end of a display controller. A microprocessor reaches the controller through one of four bus protocols. Two static strap inputs choose the protocol: an 8-bit parallel bus with either enable plus read/write signalling or separate read and write strobes, or a serial link in a 4-wire or 3-wire format. The block turns every host access into one internal transaction of four kinds: display-data write, display-data read, status read, or instruction write.

All host pins are asynchronous to the block clock. They pass through a synchronizer, and edges are detected on the block clock. Each accepted access raises a one-cycle request strobe on the internal side, together with the transaction type and, for writes, the captured byte. During a parallel read, the read data from the internal side goes to the host data bus. The bus is driven only while the read access is active. The tri-state pad sits outside the block: `data_oe_o` low means high impedance.

Top module: `hbi_host_if`

## Requirements
- R1: While `cs_ni` is high, the host pins raise no request, and toggling `rs_i`, `e_rd_i`, `rw_wr_i` or `sclk_i` has no effect.
- R2: With `ps0_i`=1 and `ps1_i`=1 (enable mode), a write (`rw_wr_i`=0) is captured on the falling edge of the enable `e_rd_i`. The type is given by `rs_i`, and the byte is the `data_i` value held before that edge.
- R3: In enable mode, a read (`rw_wr_i`=1) raises a request when the enable rises with `cs_ni` low. While the read is active, `data_o` equals `rd_data_i` and `data_oe_o` is 1.
- R4: With `ps0_i`=1 and `ps1_i`=0 (strobe mode), a write is `rw_wr_i` low with `e_rd_i` high. It is captured on the rising (trailing) edge of `rw_wr_i`.
- R5: In strobe mode, a read is `e_rd_i` low with `rw_wr_i` high. It raises a request on the leading edge, and the bus is driven with `rd_data_i` while the read is active.
- R6: In enable mode with `e_rd_i` held high, `cs_ni` acts as the enable. A write is captured when `cs_ni` rises, using the `rs_i` and `data_i` values held before that edge.
- R7: With `ps0_i`=0 and `ps1_i`=1, serial bytes are shifted MSB first on rising `sclk_i` edges. `rs_i` is sampled on the eighth edge and selects data write or instruction write.
- R8: With `ps0_i`=0 and `ps1_i`=0, each serial frame has 9 bits. The first bit is the tag (1 = data write, 0 = instruction write), followed by 8 data bits, MSB first.
- R9: Raising `cs_ni` in the middle of a serial frame discards the partial bits. The next frame starts from bit zero.
- R10: `data_oe_o` is 0 except during an active parallel read. It is always 0 in serial mode and after a read ends.
- R11: After reset, `req_o` and `data_oe_o` are 0.
- R12: `req_type_o` is encoded as {register-select, read}: 00 instruction write, 01 status read, 10 data write, 11 data read. `req_data_o` is valid for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ps0_i | input | 1 | Strap: 1 parallel, 0 serial |
| ps1_i | input | 1 | Strap: parallel 1 enable mode / 0 strobe mode; serial 1 4-wire / 0 3-wire |
| cs_ni | input | 1 | Active-low chip select |
| rs_i | input | 1 | Register select: 1 display data, 0 instruction/status |
| e_rd_i | input | 1 | Enable (enable mode) or active-low read strobe (strobe mode) |
| rw_wr_i | input | 1 | Read/write level (enable mode) or active-low write strobe (strobe mode) |
| data_i | input | 8 | Host data bus, inbound |
| data_o | output | 8 | Host data bus, outbound |
| data_oe_o | output | 1 | Bus drive enable; 0 means high impedance |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| req_o | output | 1 | One-cycle internal transaction strobe |
| req_type_o | output | 2 | Transaction type {rs, read} |
| req_data_o | output | 8 | Captured write byte |
| rd_data_i | input | 8 | Read byte returned from the internal side |

## Verification
A wrong edge detector or a stale capture register shows up within a few clocks of the strobe's trailing edge. The symptom is a request of the wrong type, a byte from an earlier access, or no request at all, and each expected transaction is matched against the next strobe. A serial bit counter that is not cleared misaligns the next frame. The byte then arrives shifted, or with the wrong tag, on the first full frame after a deselect. A faulty bus-drive gate shows as `data_oe_o` still high several clocks after the read strobe has been released.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int unsigned DW = 8;

  // encoding is {register_select, read}
  typedef enum logic [1:0] {
    TXN_INSTR_WR  = 2'b00,
    TXN_STATUS_RD = 2'b01,
    TXN_DATA_WR   = 2'b10,
    TXN_DATA_RD   = 2'b11
  } txn_e;

  function automatic txn_e txn_of(input logic rs, input logic rd);
    return txn_e'({rs, rd});
  endfunction
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hbi_par.sv
module hbi_par
  import hbi_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         m_enable_i,
  input  logic         cs_s_i,
  input  logic         rs_s_i,
  input  logic         e_rd_s_i,
  input  logic         rw_wr_s_i,
  input  logic [W-1:0] dat_s_i,
  output logic         req_o,
  output txn_e         type_o,
  output logic [W-1:0] data_o,
  output logic         oe_o
);
  logic act_rd, act_wr, act_rd_q, act_wr_q, rs_q;
  logic rd_start, wr_end;
  logic [W-1:0] dat_q;

  // enable mode: tying e high turns chip select into the enable
  always_comb begin
    if (m_enable_i) begin
      act_rd = !cs_s_i && e_rd_s_i && rw_wr_s_i;
      act_wr = !cs_s_i && e_rd_s_i && !rw_wr_s_i;
    end else begin
      act_rd = !cs_s_i && !e_rd_s_i && rw_wr_s_i;
      act_wr = !cs_s_i && e_rd_s_i && !rw_wr_s_i;
    end
  end

  assign rd_start = en_i && act_rd && !act_rd_q;
  assign wr_end   = en_i && !act_wr && act_wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_rd_q <= 1'b0;
      act_wr_q <= 1'b0;
      rs_q     <= 1'b0;
      dat_q    <= '0;
      req_o    <= 1'b0;
      type_o   <= TXN_INSTR_WR;
      data_o   <= '0;
    end else begin
      act_rd_q <= act_rd;
      act_wr_q <= act_wr;
      rs_q     <= rs_s_i;
      dat_q    <= dat_s_i;
      req_o    <= rd_start || wr_end;
      if (rd_start)    type_o <= txn_of(rs_s_i, 1'b1);
      else if (wr_end) type_o <= txn_of(rs_q, 1'b0);
      if (wr_end) data_o <= dat_q;
    end
  end

  assign oe_o = en_i && act_rd;

  p_wr_trailing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !type_o[0] |-> $past(act_wr_q) && !act_wr_q);
  p_rd_driven_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && type_o[0] |-> $past(oe_o));
endmodule

// File: rtl/hbi_ser.sv
module hbi_ser
  import hbi_pkg::*;
#(
  parameter int unsigned BITS = DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            four_wire_i,
  input  logic            cs_s_i,
  input  logic            rs_s_i,
  input  logic            sclk_s_i,
  input  logic            sdi_s_i,
  output logic            req_o,
  output txn_e            type_o,
  output logic [BITS-1:0] data_o
);
  localparam int unsigned CW = $clog2(BITS + 1);

  logic [CW-1:0]   cnt;
  logic [BITS-1:0] sh;
  logic            sclk_q, rise, last;

  assign rise = sclk_s_i && !sclk_q;
  assign last = four_wire_i ? (cnt == CW'(BITS - 1)) : (cnt == CW'(BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      req_o  <= 1'b0;
      type_o <= TXN_INSTR_WR;
      data_o <= '0;
    end else begin
      sclk_q <= sclk_s_i;
      req_o  <= 1'b0;
      if (!en_i || cs_s_i) begin
        cnt <= '0;
        sh  <= '0;
      end else if (rise) begin
        if (last) begin
          cnt    <= '0;
          req_o  <= 1'b1;
          data_o <= {sh[BITS-2:0], sdi_s_i};
          // 3-wire: tag bit has reached the top of the shifter
          type_o <= txn_of(four_wire_i ? rs_s_i : sh[BITS-1], 1'b0);
        end else begin
          cnt <= cnt + 1'b1;
        end
        sh <= {sh[BITS-2:0], sdi_s_i};
      end
    end
  end

  p_cnt_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |=> cnt == '0);
  p_cnt_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(BITS));
  p_ser_write_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> !type_o[0]);
endmodule

// File: rtl/hbi_host_if.sv
module hbi_host_if
  import hbi_pkg::*;
#(
  parameter int unsigned W      = DW,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ps0_i,
  input  logic         ps1_i,
  input  logic         cs_ni,
  input  logic         rs_i,
  input  logic         e_rd_i,
  input  logic         rw_wr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o,
  output logic         data_oe_o,
  input  logic         sclk_i,
  input  logic         sdi_i,
  output logic         req_o,
  output logic [1:0]   req_type_o,
  output logic [W-1:0] req_data_o,
  input  logic [W-1:0] rd_data_i
);
  localparam int unsigned SW = W + 8;
  localparam logic [SW-1:0] SRST = {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, {W{1'b0}}};

  logic [SW-1:0] pins_s;
  logic ps0_s, ps1_s, cs_s, rs_s, e_rd_s, rw_wr_s, sclk_s, sdi_s;
  logic [W-1:0] dat_s;

  hbi_sync #(.W(SW), .STAGES(STAGES), .RST_VAL(SRST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ps0_i, ps1_i, cs_ni, rs_i, e_rd_i, rw_wr_i, sclk_i, sdi_i, data_i}),
    .q_o   (pins_s)
  );

  assign {ps0_s, ps1_s, cs_s, rs_s, e_rd_s, rw_wr_s, sclk_s, sdi_s, dat_s} = pins_s;

  logic         par_req, ser_req, par_oe;
  txn_e         par_type, ser_type;
  logic [W-1:0] par_data, ser_data;

  hbi_par #(.W(W)) u_par (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (ps0_s),
    .m_enable_i(ps1_s),
    .cs_s_i    (cs_s),
    .rs_s_i    (rs_s),
    .e_rd_s_i  (e_rd_s),
    .rw_wr_s_i (rw_wr_s),
    .dat_s_i   (dat_s),
    .req_o     (par_req),
    .type_o    (par_type),
    .data_o    (par_data),
    .oe_o      (par_oe)
  );

  hbi_ser #(.BITS(W)) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (!ps0_s),
    .four_wire_i(ps1_s),
    .cs_s_i     (cs_s),
    .rs_s_i     (rs_s),
    .sclk_s_i   (sclk_s),
    .sdi_s_i    (sdi_s),
    .req_o      (ser_req),
    .type_o     (ser_type),
    .data_o     (ser_data)
  );

  assign req_o      = par_req || ser_req;
  assign req_type_o = par_req ? par_type : ser_type;
  assign req_data_o = par_req ? par_data : ser_data;
  assign data_o     = rd_data_i;
  assign data_oe_o  = par_oe;

  p_quiet_desel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s && $past(cs_s) && $past(cs_s, 2) |-> !req_o);
  p_one_source_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({par_req, ser_req}));
  p_oe_parallel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> ps0_s && !cs_s);
endmodule

// File: tb/hbi_host_if_bench.sv
module hbi_host_if_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       ps0 = 1'b1, ps1 = 1'b1, cs_n = 1'b1, rs = 1'b0, e_rd = 1'b0, rw_wr = 1'b1;
  logic [7:0] din = '0, rd_data = '0;
  logic       sclk = 1'b0, sdi = 1'b0;
  logic [7:0] dout, req_data;
  logic       oe, req;
  logic [1:0] req_type;

  int n_run = 0, n_fail = 0;

  typedef struct { logic [1:0] t; logic [7:0] d; string tag; } exp_t;
  exp_t q[$];

  hbi_host_if u_hbi_host_if (
    .clk_i(clk), .rst_ni(rst_ni), .ps0_i(ps0), .ps1_i(ps1), .cs_ni(cs_n),
    .rs_i(rs), .e_rd_i(e_rd), .rw_wr_i(rw_wr), .data_i(din), .data_o(dout),
    .data_oe_o(oe), .sclk_i(sclk), .sdi_i(sdi), .req_o(req),
    .req_type_o(req_type), .req_data_o(req_data), .rd_data_i(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [1:0] t, input logic [7:0] d, input string tag);
    exp_t e;
    e.t = t; e.d = d; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && req) begin
      if (q.size() == 0) begin
        chk(1'b0, "R1 unexpected request", {req_type, req_data}, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(req_type == e.t, {e.tag, " type"}, req_type, e.t);
        if (!e.t[0]) chk(req_data == e.d, {e.tag, " data R12"}, req_data, e.d);
      end
    end
  end

  task automatic mode(input logic p0, input logic p1);
    cs_n = 1'b1; e_rd = p1 ? 1'b0 : 1'b1; rw_wr = 1'b1;
    ps0 = p0; ps1 = p1;
    wc(6);
  endtask

  task automatic en_write(input logic r, input logic [7:0] d);
    rs = r; rw_wr = 1'b0; din = d; wc(2);
    cs_n = 1'b0; wc(2);
    e_rd = 1'b1; wc(4);
    push({r, 1'b0}, d, "R2");
    e_rd = 1'b0; wc(4);
    din = ~d; cs_n = 1'b1; rw_wr = 1'b1; wc(4);
  endtask

  task automatic en_read(input logic r, input logic [7:0] v);
    rd_data = v; rs = r; rw_wr = 1'b1; cs_n = 1'b0; wc(2);
    push({r, 1'b1}, 8'h00, "R3");
    e_rd = 1'b1; wc(5);
    chk(oe == 1'b1, "R3 oe during read", oe, 1);
    chk(dout == v, "R3 read data", dout, v);
    e_rd = 1'b0; wc(5);
    chk(oe == 1'b0, "R10 oe after read", oe, 0);
    cs_n = 1'b1; wc(3);
  endtask

  task automatic cs_write(input logic r, input logic [7:0] d);
    rs = r; rw_wr = 1'b0; din = d; e_rd = 1'b1; wc(2);
    cs_n = 1'b0; wc(4);
    push({r, 1'b0}, d, "R6");
    cs_n = 1'b1; wc(4);
    din = ~d; rs = ~r; wc(3);
  endtask

  task automatic st_write(input logic r, input logic [7:0] d);
    rs = r; din = d; e_rd = 1'b1; cs_n = 1'b0; wc(2);
    rw_wr = 1'b0; wc(4);
    push({r, 1'b0}, d, "R4");
    rw_wr = 1'b1; wc(4);
    din = ~d; cs_n = 1'b1; wc(3);
  endtask

  task automatic st_read(input logic r, input logic [7:0] v);
    rd_data = v; rs = r; cs_n = 1'b0; wc(2);
    push({r, 1'b1}, 8'h00, "R5");
    e_rd = 1'b0; wc(5);
    chk(oe == 1'b1, "R5 oe during read", oe, 1);
    chk(dout == v, "R5 read data", dout, v);
    e_rd = 1'b1; wc(5);
    chk(oe == 1'b0, "R10 oe after strobe read", oe, 0);
    cs_n = 1'b1; wc(3);
  endtask

  task automatic sbit(input logic b);
    sdi = b; sclk = 1'b0; wc(3);
    sclk = 1'b1; wc(3);
  endtask

  task automatic ser_frame(input logic four, input logic r, input logic [7:0] d, input string tag);
    rs = r; cs_n = 1'b0; wc(3);
    if (!four) sbit(r);
    for (int i = 7; i >= 0; i--) sbit(d[i]);
    push({r, 1'b0}, d, tag);
    sclk = 1'b0; wc(3);
    chk(oe == 1'b0, "R10 oe in serial", oe, 0);
    cs_n = 1'b1; wc(4);
  endtask

  initial begin
    wc(3);
    chk(req == 1'b0, "R11 req in reset", req, 0);
    chk(oe == 1'b0, "R11 oe in reset", oe, 0);
    rst_ni = 1'b1; wc(3);
    chk(req == 1'b0, "R11 req after reset", req, 0);

    // enable mode
    mode(1'b1, 1'b1);
    en_write(1'b1, 8'hA5);
    en_write(1'b0, 8'h3C);
    en_read(1'b1, 8'h5A);
    en_read(1'b0, 8'hC3);

    // R1: deselected noise
    cs_n = 1'b1; rs = 1'b1; rw_wr = 1'b1;
    for (int i = 0; i < 4; i++) begin
      e_rd = 1'b1; wc(4);
      chk(oe == 1'b0, "R1 oe deselected", oe, 0);
      rw_wr = 1'b0; wc(3); e_rd = 1'b0; wc(3); rw_wr = 1'b1;
    end
    wc(4);
    chk(q.size() == 0, "R1 queue after noise", q.size(), 0);

    // R6: chip select as enable
    cs_write(1'b1, 8'h81);
    cs_write(1'b0, 8'h7E);
    e_rd = 1'b0;

    // strobe mode
    mode(1'b1, 1'b0);
    st_write(1'b1, 8'h12);
    st_write(1'b0, 8'hFE);
    st_read(1'b1, 8'h99);
    st_read(1'b0, 8'h01);

    // serial 4-wire
    mode(1'b0, 1'b1);
    ser_frame(1'b1, 1'b1, 8'hB4, "R7");
    ser_frame(1'b1, 1'b0, 8'h2D, "R7");
    cs_n = 1'b1;
    for (int i = 0; i < 5; i++) sbit(i[0]);
    wc(4);
    chk(q.size() == 0, "R1 serial deselected", q.size(), 0);

    // serial 3-wire
    mode(1'b0, 1'b0);
    ser_frame(1'b0, 1'b1, 8'hC9, "R8");
    ser_frame(1'b0, 1'b0, 8'h36, "R8");

    // R9: aborted partial frame
    cs_n = 1'b0; wc(3);
    sbit(1'b1); sbit(1'b1); sbit(1'b0);
    sclk = 1'b0; cs_n = 1'b1; wc(5);
    ser_frame(1'b0, 1'b1, 8'h6B, "R9");
    mode(1'b0, 1'b1);
    cs_n = 1'b0; wc(3);
    sbit(1'b0); sbit(1'b1);
    sclk = 1'b0; cs_n = 1'b1; wc(5);
    ser_frame(1'b1, 1'b0, 8'h94, "R9");

    wc(10);
    chk(q.size() == 0, "R12 all requests seen", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog R12 actual=%0d expected=%0d", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule